// File: doc/BRIEF.md
# DMA Address Table-Walk Translator

This block turns a device-side (DMA) virtual address into a physical address by reading a single entry from a translation table in memory. A requester presents a virtual address and a read/write flag on a valid/ready handshake. The control and table-base register values arrive as plain inputs. Only one request is in flight at a time, and there is no translation cache.

When translation is off, the address passes straight through. When translation is on, the block forms the table-entry address from a window of virtual-address bits. It issues one 64-bit read on a request/grant/data-valid memory port. It then decodes the returned entry into a physical address, a permission code, a page-size flag and a fault flag.

The control sequence is a four-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_FETCH` for a table read. It moves straight to `ST_RESPOND` for a passthrough or for an unsupported size code.
- `ST_FETCH` holds the memory request until it is granted, then moves to `ST_WAIT_DATA`.
- `ST_WAIT_DATA` waits for the entry data, then moves to `ST_RESPOND`.
- `ST_RESPOND` holds the response until it is taken, then returns to `ST_IDLE`.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: With control bit 0 clear, the response follows one cycle after acceptance. It carries `rsp_paddr` equal to the virtual address, `rsp_perm` = 2'b11 (read/write), `rsp_fault` = 0 and `rsp_page64k` = 0 (8 KB granule). No memory read is issued.
- R3: With control bit 0 set and bit 2 clear (8 KB table), the entry read address is `cfg_base` + 8 × vaddr[22+n:13]. Here n is control bits 18:16 and ranges over 0..7.
- R4: With control bits 0 and 2 set (64 KB table) and n in 0..5, the entry read address is `cfg_base` + 8 × vaddr[25+n:16].
- R5: With a 64 KB table and n equal to 6 or 7, the response follows one cycle after acceptance. It carries `rsp_fault` = 1, `rsp_perm` = 2'b00 and `rsp_paddr` = 0, and no memory read is issued.
- R6: A returned entry with bit 63 clear gives `rsp_fault` = 1, `rsp_perm` = 2'b00 and `rsp_paddr` = 0. `mem_rdata` carries the entry as a 64-bit value, with the byte at the lowest address in bits 63:56.
- R7: For a valid entry, bit 1 set gives `rsp_perm` = 2'b11 and bit 1 clear gives `rsp_perm` = 2'b01 (read-only).
- R8: A valid entry with bit 61 clear gives an 8 KB page: `rsp_paddr` = {entry[40:13], vaddr[12:0]} and `rsp_page64k` = 0.
- R9: A valid entry with bit 61 set gives a 64 KB page: `rsp_paddr` = (entry bits 40:15) OR vaddr[15:0], and `rsp_page64k` = 1.
- R10: A write request (`req_write` = 1) that hits a valid read-only entry gives `rsp_fault` = 1, `rsp_perm` = 2'b01, and still reports the decoded physical address.
- R11: The handshakes behave as follows:
  - `req_ready` is 0 from acceptance until the response is taken.
  - `mem_req` and `mem_addr` stay steady until `mem_gnt`.
  - The response stays valid and unchanged until `rsp_ready`.
  - A table walk answers 3 + g cycles after acceptance, where g is the number of cycles the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_ctrl | input | 32 | Control: bit 0 enable, bit 2 table page size, bits 18:16 size code |
| cfg_base | input | 64 | Table base byte address |
| mem_req | output | 1 | Entry read request |
| mem_gnt | input | 1 | Entry read request accepted |
| mem_addr | output | 64 | Entry byte address |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 64 | Entry data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 64 | Translated physical address |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read/write |
| rsp_fault | output | 1 | Translation or permission fault |
| rsp_page64k | output | 1 | 1 = 64 KB page granule, 0 = 8 KB |

## Verification
The hardest situations to reach are the ones where the design must hold state while the other side stalls. Examples are a withheld memory grant with the read address sitting on the port, or a finished response kept waiting on `rsp_ready` while the core must neither change it nor accept new work. The bench's memory model withholds the grant for a chosen number of cycles and the response sink refuses for a chosen number of cycles. Each cycle of those windows compares the address, the response and `req_ready` against the first values seen. Size codes at both ends of each table range use addresses with ones above the index window, so a window that is too wide or too narrow shows up in `mem_addr`.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;

    parameter int unsigned WALK_AW = 64;

    localparam int unsigned CTL_EN_BIT     = 0;
    localparam int unsigned CTL_BIGTBL_BIT = 2;
    localparam int unsigned CTL_SZ_LSB     = 16;
    localparam int unsigned CTL_SZ_W       = 3;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RO   = 2'b01;
    localparam logic [1:0] PERM_RW   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_DATA,
        ST_RESPOND
    } walk_state_t;

    typedef struct packed {
        logic [WALK_AW-1:0] paddr;
        logic [1:0]         perm;
        logic               fault;
        logic               page64k;
    } xlat_rsp_t;

endpackage

// File: rtl/iova_tbl_index.sv
module iova_tbl_index
    import iova_walk_pkg::*;
#(
    parameter int unsigned AW             = WALK_AW,
    parameter int unsigned IDX_MIN_BITS   = 10,
    parameter int unsigned SMALL_SHIFT    = 13,
    parameter int unsigned LARGE_SHIFT    = 16,
    parameter int unsigned ENTRY_BYTES_LG = 3,
    parameter int unsigned MAX_LARGE_CODE = 5
) (
    input  logic [AW-1:0]       vaddr,
    input  logic [AW-1:0]       base,
    input  logic                large_tbl,
    input  logic [CTL_SZ_W-1:0] size_code,
    output logic [AW-1:0]       entry_addr,
    output logic                code_ok
);
    localparam int unsigned SHW = $clog2(AW);

    logic [AW-1:0]  shifted;
    logic [AW-1:0]  keep_mask;
    logic [SHW-1:0] idx_bits;

    always_comb begin
        shifted    = large_tbl ? (vaddr >> LARGE_SHIFT) : (vaddr >> SMALL_SHIFT);
        idx_bits   = SHW'(IDX_MIN_BITS) + SHW'(size_code);
        keep_mask  = (AW'(1) << idx_bits) - AW'(1);
        entry_addr = base + ((shifted & keep_mask) << ENTRY_BYTES_LG);
        code_ok    = !large_tbl || (size_code <= CTL_SZ_W'(MAX_LARGE_CODE));
    end

endmodule

// File: rtl/iova_entry_decode.sv
module iova_entry_decode
    import iova_walk_pkg::*;
#(
    parameter int unsigned AW         = WALK_AW,
    parameter int unsigned EW         = 64,
    parameter int unsigned VALID_BIT  = 63,
    parameter int unsigned BIG_BIT    = 61,
    parameter int unsigned WR_BIT     = 1,
    parameter int unsigned PA_MSB     = 40,
    parameter int unsigned SMALL_LSB  = 13,
    parameter int unsigned LARGE_LSB  = 15,
    parameter int unsigned LARGE_OFSW = 16
) (
    input  logic [EW-1:0] entry,
    input  logic [AW-1:0] vaddr,
    input  logic          wr_req,
    output xlat_rsp_t     rsp
);
    localparam logic [AW-1:0] PA_FIELD  = (AW'(1) << (PA_MSB + 1)) - AW'(1);
    localparam logic [AW-1:0] SMALL_OFS = (AW'(1) << SMALL_LSB) - AW'(1);
    localparam logic [AW-1:0] LARGE_BAS = (AW'(1) << LARGE_LSB) - AW'(1);
    localparam logic [AW-1:0] LARGE_OFS = (AW'(1) << LARGE_OFSW) - AW'(1);

    logic          ent_valid;
    logic          ent_big;
    logic          ent_wr;
    logic [AW-1:0] ent_word;

    always_comb begin
        ent_word  = AW'(entry);
        ent_valid = entry[VALID_BIT];
        ent_big   = entry[BIG_BIT];
        ent_wr    = entry[WR_BIT];

        rsp = '0;
        if (ent_valid) begin
            rsp.perm    = ent_wr ? PERM_RW : PERM_RO;
            rsp.fault   = wr_req && !ent_wr;
            rsp.page64k = ent_big;
            if (ent_big) begin
                rsp.paddr = (ent_word & PA_FIELD & ~LARGE_BAS) | (vaddr & LARGE_OFS);
            end else begin
                rsp.paddr = (ent_word & PA_FIELD & ~SMALL_OFS) | (vaddr & SMALL_OFS);
            end
        end else begin
            rsp.perm  = PERM_NONE;
            rsp.fault = 1'b1;
        end
    end

endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iova_walk_pkg::*;
#(
    parameter int unsigned AW  = WALK_AW,
    parameter int unsigned CW  = 32,
    parameter int unsigned EW  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic [CW-1:0] cfg_ctrl,
    input  logic [AW-1:0] cfg_base,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [EW-1:0] mem_rdata,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_perm,
    output logic          rsp_fault,
    output logic          rsp_page64k
);
    walk_state_t state_q, state_d;

    logic [AW-1:0] va_q;
    logic          wr_q;
    logic [AW-1:0] maddr_q;
    xlat_rsp_t     rsp_q;

    logic          accept;
    logic          xlat_on;
    logic [AW-1:0] idx_addr;
    logic          idx_code_ok;
    xlat_rsp_t     dec_rsp;

    assign xlat_on = cfg_ctrl[CTL_EN_BIT];
    assign accept  = req_valid && (state_q == ST_IDLE);

    iova_tbl_index #(.AW(AW)) u_index (
        .vaddr      (req_vaddr),
        .base       (cfg_base),
        .large_tbl  (cfg_ctrl[CTL_BIGTBL_BIT]),
        .size_code  (cfg_ctrl[CTL_SZ_LSB +: CTL_SZ_W]),
        .entry_addr (idx_addr),
        .code_ok    (idx_code_ok)
    );

    iova_entry_decode #(.AW(AW), .EW(EW)) u_decode (
        .entry  (mem_rdata),
        .vaddr  (va_q),
        .wr_req (wr_q),
        .rsp    (dec_rsp)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (!xlat_on || !idx_code_ok) ? ST_RESPOND : ST_FETCH;
                end
            end
            ST_FETCH:     if (mem_gnt)    state_d = ST_WAIT_DATA;
            ST_WAIT_DATA: if (mem_rvalid) state_d = ST_RESPOND;
            ST_RESPOND:   if (rsp_ready)  state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and response holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            maddr_q <= '0;
            rsp_q   <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                maddr_q <= idx_addr;
                if (!xlat_on) begin
                    rsp_q.paddr   <= req_vaddr;
                    rsp_q.perm    <= PERM_RW;
                    rsp_q.fault   <= 1'b0;
                    rsp_q.page64k <= 1'b0;
                end else if (!idx_code_ok) begin
                    rsp_q.paddr   <= '0;
                    rsp_q.perm    <= PERM_NONE;
                    rsp_q.fault   <= 1'b1;
                    rsp_q.page64k <= 1'b0;
                end
            end
            if ((state_q == ST_WAIT_DATA) && mem_rvalid) begin
                rsp_q <= dec_rsp;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_req     = (state_q == ST_FETCH);
        mem_addr    = maddr_q;
        rsp_valid   = (state_q == ST_RESPOND);
        rsp_paddr   = rsp_q.paddr;
        rsp_perm    = rsp_q.perm;
        rsp_fault   = rsp_q.fault;
        rsp_page64k = rsp_q.page64k;
    end

endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk
    import iova_walk_pkg::*;
#(
    parameter int unsigned AW = WALK_AW,
    parameter int unsigned CW = 32,
    parameter int unsigned EW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic [CW-1:0] cfg_ctrl,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_paddr,
    input logic [1:0]    rsp_perm,
    input logic          rsp_fault
);
    logic take;
    assign take = req_valid && req_ready;

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> !req_ready);

    p_passthru_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cfg_ctrl[CTL_EN_BIT]) |=>
            (rsp_valid && rsp_paddr == $past(req_vaddr) && rsp_perm == PERM_RW && !rsp_fault && !mem_req));

    p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_ctrl[CTL_EN_BIT] && cfg_ctrl[CTL_BIGTBL_BIT] && (cfg_ctrl[CTL_SZ_LSB+1 +: 2] == 2'b11)) |=>
            (rsp_valid && rsp_fault && rsp_perm == PERM_NONE && !mem_req));

    p_memreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm) && $stable(rsp_fault)));

    p_noperm_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == PERM_NONE) |-> rsp_fault);

endmodule

bind iova_walker iova_walker_chk #(.AW(AW), .CW(CW), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .cfg_ctrl  (cfg_ctrl),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_perm  (rsp_perm),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_iova_walker.sv
module tb_iova_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] cfg_ctrl = '0;
    logic [63:0] cfg_base = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;
    logic        rsp_page64k;

    always #5 clk = ~clk;

    iova_walker dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // results of the last transaction
    logic        o_mem, o_addr_move, o_hold_bad, o_ready_bad;
    logic [63:0] o_maddr, o_pa;
    logic [1:0]  o_perm;
    logic        o_flt, o_big;
    int          o_lat;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] tbl_addr(input logic [63:0] va, input logic [63:0] bas,
                                             input logic big, input int n);
        logic [63:0] win;
        win = big ? (va >> 16) : (va >> 13);
        win = win & ((64'd1 << (10 + n)) - 64'd1);
        return bas + win * 64'd8;
    endfunction

    task automatic run_xlat(input logic [63:0] va, input logic wr, input logic [31:0] ctl,
                            input logic [63:0] bas, input logic [63:0] ent,
                            input int gdly, input int hold);
        int  gwait = 0;
        int  hleft = hold;
        logic due  = 1'b0;
        logic seen = 1'b0;
        o_mem = 0; o_maddr = '0; o_addr_move = 0; o_hold_bad = 0; o_ready_bad = 0;
        o_lat = -1; o_pa = '0; o_perm = '0; o_flt = 0; o_big = 0;
        cfg_ctrl = ctl; cfg_base = bas; req_vaddr = va; req_write = wr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc < 40; cyc++) begin
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (due) begin
                mem_rvalid = 1'b1;
                mem_rdata  = ent;
                due = 1'b0;
            end
            if (req_ready) o_ready_bad = 1'b1;
            if (mem_req) begin
                if (o_mem && mem_addr !== o_maddr) o_addr_move = 1'b1;
                o_mem = 1'b1;
                o_maddr = mem_addr;
                if (gwait >= gdly) begin
                    mem_gnt = 1'b1;
                    due = 1'b1;
                end
                gwait++;
            end
            if (rsp_valid) begin
                if (!seen) begin
                    seen = 1'b1;
                    o_lat = cyc; o_pa = rsp_paddr; o_perm = rsp_perm;
                    o_flt = rsp_fault; o_big = rsp_page64k;
                end else if (rsp_paddr !== o_pa || rsp_perm !== o_perm || rsp_fault !== o_flt) begin
                    o_hold_bad = 1'b1;
                end
                if (hleft == 0) begin
                    rsp_ready = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    rsp_ready = 1'b0;
                    break;
                end
                hleft--;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 mem_req", 64'(mem_req), 64'd0);
    endtask

    task automatic t_passthru;
        logic [63:0] va = 64'hFEDC_BA98_7654_3211;
        run_xlat(va, 1'b1, 32'h0007_0004, 64'h1000, 64'h0, 0, 0);
        chk("R2 paddr", o_pa, va);
        chk("R2 perm", 64'(o_perm), 64'd3);
        chk("R2 fault", 64'(o_flt), 64'd0);
        chk("R2 granule", 64'(o_big), 64'd0);
        chk("R2 no mem read", 64'(o_mem), 64'd0);
        chk("R2 latency", 64'(o_lat), 64'd1);
        chk("R11 ready after rsp", 64'(req_ready), 64'd1);
    endtask

    task automatic t_small_tbl(input int n);
        logic [63:0] va  = 64'hFFFF_FFFF_FFFF_E5A5 ^ 64'h0000_0000_2AAA_0000;
        logic [63:0] bas = 64'h0000_0040_0000_0000;
        logic [63:0] ent = 64'h8000_0000_0000_0002 | 64'h0000_0155_5555_6000 | 64'h0000_0000_0000_1FFC;
        run_xlat(va, 1'b1, 32'(n) << 16 | 32'h1, bas, ent, 2, 2);
        chk($sformatf("R3 entry addr n=%0d", n), o_maddr, tbl_addr(va, bas, 1'b0, n));
        chk("R11 mem_addr steady", 64'(o_addr_move), 64'd0);
        chk("R11 rsp steady", 64'(o_hold_bad), 64'd0);
        chk("R11 busy not ready", 64'(o_ready_bad), 64'd0);
        chk("R11 walk latency", 64'(o_lat), 64'd5);
        chk("R8 paddr", o_pa, (ent & 64'h1FF_FFFF_E000) | (va & 64'h1FFF));
        chk("R8 granule", 64'(o_big), 64'd0);
        chk("R7 perm rw", 64'(o_perm), 64'd3);
        chk("R7 no fault", 64'(o_flt), 64'd0);
    endtask

    task automatic t_large_tbl(input int n);
        logic [63:0] va  = 64'hFFFF_FFFF_D5B3_9ABC;
        logic [63:0] bas = 64'h0000_0000_8000_0008;
        logic [63:0] ent = 64'hA000_0000_0000_0000 | 64'h0000_01AB_CDEF_8000;
        run_xlat(va, 1'b0, 32'(n) << 16 | 32'h5, bas, ent, 0, 0);
        chk($sformatf("R4 entry addr n=%0d", n), o_maddr, tbl_addr(va, bas, 1'b1, n));
        chk("R9 paddr", o_pa, (ent & 64'h1FF_FFFF_8000) | (va & 64'hFFFF));
        chk("R9 granule", 64'(o_big), 64'd1);
        chk("R7 perm ro", 64'(o_perm), 64'd1);
        chk("R7 read ok", 64'(o_flt), 64'd0);
        chk("R11 walk latency", 64'(o_lat), 64'd3);
    endtask

    task automatic t_bad_code(input int n);
        run_xlat(64'h1234_5678, 1'b0, 32'(n) << 16 | 32'h5, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
        chk($sformatf("R5 fault n=%0d", n), 64'(o_flt), 64'd1);
        chk("R5 perm none", 64'(o_perm), 64'd0);
        chk("R5 paddr zero", o_pa, 64'd0);
        chk("R5 no mem read", 64'(o_mem), 64'd0);
        chk("R5 latency", 64'(o_lat), 64'd1);
    endtask

    task automatic t_invalid;
        run_xlat(64'h0000_0000_0123_4567, 1'b0, 32'h0000_0001, 64'h2000,
                 64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
        chk("R6 fault", 64'(o_flt), 64'd1);
        chk("R6 perm none", 64'(o_perm), 64'd0);
        chk("R6 paddr zero", o_pa, 64'd0);
        chk("R6 read issued", 64'(o_mem), 64'd1);
    endtask

    task automatic t_ro_write;
        logic [63:0] va  = 64'h0000_0000_00AB_CDEF;
        logic [63:0] ent = 64'h8000_0000_0000_0000 | 64'h0000_0012_3456_6000;
        run_xlat(va, 1'b1, 32'h0002_0001, 64'h4000, ent, 0, 0);
        chk("R10 fault", 64'(o_flt), 64'd1);
        chk("R10 perm ro", 64'(o_perm), 64'd1);
        chk("R10 paddr", o_pa, (ent & 64'h1FF_FFFF_E000) | (va & 64'h1FFF));
        chk("R3 entry addr n=2", o_maddr, tbl_addr(va, 64'h4000, 1'b0, 2));
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_small_tbl(0);
        t_small_tbl(7);
        t_large_tbl(0);
        t_large_tbl(5);
        t_bad_code(6);
        t_bad_code(7);
        t_invalid();
        t_ro_write();
        t_passthru();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule